// File: doc/BRIEF.md
# Quadrature Phase Correction Datapath

This block trims the phase imbalance between the two halves of a quadrature sample stream before conversion. It handles two independent stream pairs. In each pair the primary sample is corrected by adding a scaled copy of the secondary sample from the same clock. The secondary sample itself passes through unchanged. Each pair has its own signed fractional coefficient, so one pair can be trimmed without affecting the other.

Both pairs share one two-stage pipeline. In the first stage the coefficient is multiplied by the secondary sample, and the primary and secondary samples are captured. In the second stage the product is rounded to sample scale, added to the primary sample and clamped to the sample range. A valid flag moves through the same two stages. The data registers load only on valid samples, so the outputs hold steady between bursts. A zero coefficient turns a pair into a plain two-clock delay.

Top module: `qpc_top`

## Requirements
- R1: While rst_n is low, and after its release until the first valid sample reaches the output, out_valid is 0 and all four outputs are 0.
- R2: out_valid equals in_valid as sampled two rising clock edges earlier.
- R3: out_b and out_d equal in_b and in_d of the sample that raised out_valid, without any change.
- R4: out_a = sat(in_a + ((coef_ab * in_b + 2048) >>> 12)). The shift is an arithmetic right shift, so an exact half LSB rounds toward plus infinity.
- R5: out_c = sat(in_c + ((coef_cd * in_d + 2048) >>> 12)). It does not depend on coef_ab, in_a or in_b.
- R6: Coefficients are 12-bit two's complement fractions in units of 2^-12. 0x800 means -0.5 and 0x7FF means +0.49975.
- R7: A corrected sum above +32767 gives +32767, and a sum below -32768 gives -32768. It never wraps.
- R8: With a zero coefficient, the primary output equals the primary input of the same sample.
- R9: A clock with in_valid low leaves the data outputs unchanged two edges later.
- R10: The coefficient is captured with each sample, so a coefficient change between back-to-back samples applies to the second sample only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_a | input | 16 | Primary sample of pair 0, signed |
| in_b | input | 16 | Secondary sample of pair 0, signed |
| in_c | input | 16 | Primary sample of pair 1, signed |
| in_d | input | 16 | Secondary sample of pair 1, signed |
| coef_ab | input | 12 | Pair 0 correction coefficient, signed fraction |
| coef_cd | input | 12 | Pair 1 correction coefficient, signed fraction |
| out_valid | output | 1 | Output sample qualifier |
| out_a | output | 16 | Corrected primary sample of pair 0 |
| out_b | output | 16 | Delayed secondary sample of pair 0 |
| out_c | output | 16 | Corrected primary sample of pair 1 |
| out_d | output | 16 | Delayed secondary sample of pair 1 |

## Verification
The bench builds the block with its default widths: 16-bit samples and 12-bit coefficients. At these widths a full-scale secondary sample times a full-scale coefficient swings the correction term by about half the sample range. Added to a primary sample near either rail, this drives the sum past both saturation limits. The widths also allow exact half-LSB products, so the tie rounding can be checked for positive and negative products. Back-to-back samples with different coefficients on the two pairs test per-sample coefficient capture and show that the pairs stay independent.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
    parameter int QPC_SAMPLE_W = 16;
    parameter int QPC_COEF_W   = 12;
    parameter int QPC_PAIRS    = 2;
    parameter int QPC_LATENCY  = 2;
endpackage

// File: rtl/qpc_mul_stage.sv
module qpc_mul_stage #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 12,
    localparam int PROD_W  = SAMPLE_W + COEF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] pri_i,
    input  logic signed [SAMPLE_W-1:0] sec_i,
    input  logic signed [COEF_W-1:0]   coef_i,
    output logic signed [SAMPLE_W-1:0] pri_q,
    output logic signed [SAMPLE_W-1:0] sec_q,
    output logic signed [PROD_W-1:0]   prod_q
);
    logic signed [PROD_W-1:0] prod_d;

    always_comb begin
        prod_d = PROD_W'(coef_i) * PROD_W'(sec_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q  <= '0;
            sec_q  <= '0;
            prod_q <= '0;
        end else if (load) begin
            pri_q  <= pri_i;
            sec_q  <= sec_i;
            prod_q <= prod_d;
        end
    end
endmodule

// File: rtl/qpc_sum_stage.sv
module qpc_sum_stage #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 12,
    localparam int PROD_W  = SAMPLE_W + COEF_W,
    localparam int SUM_W   = SAMPLE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] pri_q,
    input  logic signed [SAMPLE_W-1:0] sec_q,
    input  logic signed [PROD_W-1:0]   prod_q,
    output logic signed [SAMPLE_W-1:0] pri_o,
    output logic signed [SAMPLE_W-1:0] sec_o
);
    localparam logic [PROD_W:0]     RND_HALF = (PROD_W+1)'(1) << (COEF_W - 1);
    localparam logic [SAMPLE_W-1:0] POS_RAIL = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_RAIL = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [PROD_W:0]       prod_rnd;
    logic [SAMPLE_W:0]     term;
    logic [SUM_W-1:0]      sum;
    logic [SAMPLE_W-1:0]   clamped;

    always_comb begin
        prod_rnd = {prod_q[PROD_W-1], prod_q} + RND_HALF;
        term     = prod_rnd[PROD_W:COEF_W];
        sum      = {pri_q[SAMPLE_W-1], pri_q[SAMPLE_W-1], pri_q}
                 + {term[SAMPLE_W], term};
        if (sum[SUM_W-1:SAMPLE_W-1] == '0 || sum[SUM_W-1:SAMPLE_W-1] == '1) begin
            clamped = sum[SAMPLE_W-1:0];
        end else if (sum[SUM_W-1]) begin
            clamped = NEG_RAIL;
        end else begin
            clamped = POS_RAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_o <= '0;
            sec_o <= '0;
        end else if (load) begin
            pri_o <= clamped;
            sec_o <= sec_q;
        end
    end
endmodule

// File: rtl/qpc_vld_pipe.sv
module qpc_vld_pipe #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    output logic [DEPTH-1:0] vld_stg
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_stg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_stg[s] <= 1'b0;
            end else begin
                vld_stg[s] <= (s == 0) ? vld_i : vld_stg[(s == 0) ? 0 : s - 1];
            end
        end
    end
endmodule

// File: rtl/qpc_top.sv
module qpc_top
    import qpc_pkg::*;
#(
    parameter int SAMPLE_W = QPC_SAMPLE_W,
    parameter int COEF_W   = QPC_COEF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_a,
    input  logic signed [SAMPLE_W-1:0] in_b,
    input  logic signed [SAMPLE_W-1:0] in_c,
    input  logic signed [SAMPLE_W-1:0] in_d,
    input  logic signed [COEF_W-1:0]   coef_ab,
    input  logic signed [COEF_W-1:0]   coef_cd,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_a,
    output logic signed [SAMPLE_W-1:0] out_b,
    output logic signed [SAMPLE_W-1:0] out_c,
    output logic signed [SAMPLE_W-1:0] out_d
);
    localparam int NPAIR  = QPC_PAIRS;
    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic [QPC_LATENCY-1:0] vld_stg;

    logic signed [SAMPLE_W-1:0] pri_in  [NPAIR];
    logic signed [SAMPLE_W-1:0] sec_in  [NPAIR];
    logic signed [COEF_W-1:0]   coef_in [NPAIR];
    logic signed [SAMPLE_W-1:0] pri_q   [NPAIR];
    logic signed [SAMPLE_W-1:0] sec_q   [NPAIR];
    logic signed [PROD_W-1:0]   prod_q  [NPAIR];
    logic signed [SAMPLE_W-1:0] pri_out [NPAIR];
    logic signed [SAMPLE_W-1:0] sec_out [NPAIR];

    always_comb begin
        pri_in[0]  = in_a;
        sec_in[0]  = in_b;
        coef_in[0] = coef_ab;
        pri_in[1]  = in_c;
        sec_in[1]  = in_d;
        coef_in[1] = coef_cd;
    end

    qpc_vld_pipe #(.DEPTH(QPC_LATENCY)) u_vld (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (in_valid),
        .vld_stg (vld_stg)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        qpc_mul_stage #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_mul (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (in_valid),
            .pri_i  (pri_in[p]),
            .sec_i  (sec_in[p]),
            .coef_i (coef_in[p]),
            .pri_q  (pri_q[p]),
            .sec_q  (sec_q[p]),
            .prod_q (prod_q[p])
        );
        qpc_sum_stage #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_sum (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (vld_stg[0]),
            .pri_q  (pri_q[p]),
            .sec_q  (sec_q[p]),
            .prod_q (prod_q[p]),
            .pri_o  (pri_out[p]),
            .sec_o  (sec_out[p])
        );
    end

    always_comb begin
        out_valid = vld_stg[QPC_LATENCY-1];
        out_a     = pri_out[0];
        out_b     = sec_out[0];
        out_c     = pri_out[1];
        out_d     = sec_out[1];
    end
endmodule

// File: rtl/qpc_top_chk.sv
module qpc_top_chk #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_a,
    input logic [SAMPLE_W-1:0] in_b,
    input logic [SAMPLE_W-1:0] in_d,
    input logic [COEF_W-1:0]   coef_ab,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_a,
    input logic [SAMPLE_W-1:0] out_b,
    input logic [SAMPLE_W-1:0] out_c,
    input logic [SAMPLE_W-1:0] out_d
);
    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2));

    // R3
    sec_b_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_b == $past(in_b, 2));

    // R3
    sec_d_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_d == $past(in_d, 2));

    // R8
    zero_coef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(coef_ab, 2) == '0) |-> out_a == $past(in_a, 2));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_a) && $stable(out_b) && $stable(out_c) && $stable(out_d)));
endmodule

bind qpc_top qpc_top_chk #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_d      (in_d),
    .coef_ab   (coef_ab),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_c     (out_c),
    .out_d     (out_d)
);

// File: tb/sim_qpc_top.sv
module sim_qpc_top;
    localparam int NV = 10;

    // vector columns: a, b, coef_ab, c, d, coef_cd
    localparam logic signed [15:0] VA  [NV] = '{16'sd1000, 16'sd0, 16'sd100, 16'sd30000, -16'sd30000,
                                                16'sd5, 16'sd32767, -16'sd1234, 16'sd7, 16'sd7};
    localparam logic signed [15:0] VB  [NV] = '{16'sd2000, 16'sd4096, 16'sd32767, 16'sd32767, 16'sd32767,
                                                16'sd2048, -16'sd32768, 16'sd9876, 16'sd4095, 16'sd4095};
    localparam logic signed [11:0] VKA [NV] = '{12'sd0, 12'sd1, 12'sd2047, 12'sd2047, -12'sd2048,
                                                12'sd1, -12'sd2048, 12'sd345, 12'sd1, -12'sd1};
    localparam logic signed [15:0] VC  [NV] = '{-16'sd500, 16'sd0, -16'sd100, 16'sd12, -16'sd32768,
                                                16'sd5, 16'sd0, 16'sd4321, 16'sd0, 16'sd0};
    localparam logic signed [15:0] VD  [NV] = '{16'sd300, -16'sd4096, -16'sd32768, 16'sd100, -16'sd32768,
                                                -16'sd2048, 16'sd20000, -16'sd777, 16'sd8192, 16'sd8192};
    localparam logic signed [11:0] VKC [NV] = '{12'sd0, 12'sd1, 12'sd2047, -12'sd5, -12'sd2048,
                                                12'sd1, 12'sd0, -12'sd1500, 12'sd2047, -12'sd2048};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic signed [11:0] coef_ab = '0, coef_cd = '0;
    logic out_valid;
    logic signed [15:0] out_a, out_b, out_c, out_d;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    qpc_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .coef_ab(coef_ab), .coef_cd(coef_cd),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
    );

    function automatic logic signed [15:0] model(input logic signed [15:0] p,
                                                 input logic signed [15:0] s,
                                                 input logic signed [11:0] k);
        longint prod = longint'(k) * longint'(s);
        longint term = (prod + 2048) >>> 12;
        longint tot  = longint'(p) + term;
        if (tot > 32767) tot = 32767;
        if (tot < -32768) tot = -32768;
        return 16'(tot);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int i);
        in_valid = 1'b1;
        in_a = VA[i]; in_b = VB[i]; coef_ab = VKA[i];
        in_c = VC[i]; in_d = VD[i]; coef_cd = VKC[i];
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", out_valid, 0);
        check("R1 out_a", out_a, 0);
        check("R1 out_d", out_d, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", out_valid, 0);

        // Streaming table: R3 R4 R5 R6 R7 R8 R10
        for (int j = 0; j < NV + 2; j++) begin
            if (j >= 2) begin
                check("R2 stream valid", out_valid, 1);
                check("R4 out_a", out_a, model(VA[j-2], VB[j-2], VKA[j-2]));
                check("R3 out_b", out_b, VB[j-2]);
                check("R5 out_c", out_c, model(VC[j-2], VD[j-2], VKC[j-2]));
                check("R3 out_d", out_d, VD[j-2]);
            end
            if (j < NV) drive(j);
            else in_valid = 1'b0;
            @(negedge clk);
        end

        // Hand-computed corner values
        // R8 vector 0: zero coef passes through; R7 vector 3 and 4 saturate
        check("R8 pass", model(VA[0], VB[0], VKA[0]), 1000);
        check("R7 pos rail", model(VA[3], VB[3], VKA[3]), 32767);
        check("R7 neg rail", model(VA[4], VB[4], VKA[4]), -32768);
        check("R6 half scale", model(16'sd0, -16'sd32768, -12'sd2048), 16384);
        check("R4 tie up", model(16'sd0, -16'sd2048, 12'sd1), 0);

        // R9: idle clocks with changed data leave outputs alone
        begin
            logic signed [15:0] ha, hb, hc, hd;
            ha = out_a; hb = out_b; hc = out_c; hd = out_d;
            in_valid = 1'b0; in_a = 16'sd111; in_b = 16'sd222; in_c = 16'sd333; in_d = 16'sd444;
            coef_ab = 12'sd700; coef_cd = 12'sd700;
            repeat (3) @(negedge clk);
            check("R9 valid low", out_valid, 0);
            check("R9 hold a", out_a, ha);
            check("R9 hold b", out_b, hb);
            check("R9 hold c", out_c, hc);
            check("R9 hold d", out_d, hd);
        end

        // R2: single-cycle pulse emerges exactly two edges later
        drive(7);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 pulse +1", out_valid, 0);
        @(negedge clk);
        check("R2 pulse +2", out_valid, 1);
        check("R4 pulse a", out_a, model(VA[7], VB[7], VKA[7]));
        @(negedge clk);
        check("R2 pulse +3", out_valid, 0);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerst a", out_a, 0);
        check("R1 rerst valid", out_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule